// File: doc/BRIEF.md
# On/Off Cycle-Skipping Switch Controller

This block decides, one switching period at a time, whether the primary switch of an on/off regulated flyback converter conducts, and for how long. At each period-start pulse from the oscillator it samples a single feedback-enable flag. If the flag is high and no protection is active, it raises the gate output. Otherwise it skips the whole period and emits a one-tick skip pulse that downstream logic can count. Later changes of the feedback flag in that period have no effect.

A conducting pulse is timed in fast-clock ticks. It ends at the maximum on-time, which is derived from the period length and the duty limit. It also ends on a current-limit flag, but only once a leading-edge blanking window after turn-on has passed. Three protection state machines gate every decision. The supply-undervoltage machine has hysteresis: states `UV_LOCK` and `UV_RUN`, with transitions *brown-out* (LOCK entered) and *recharged* (RUN entered). The overvoltage machine is a latch: states `OV_CLEAR` and `OV_TRIPPED`, with transitions *trip* and *discharge reset*. The thermal machine has states `OT_COOL` and `OT_HOT`, with transitions *overheat* and *cooled*.

The cycle machine has states `CY_IDLE` (gate off), `CY_BLANK` (gate on, current limit ignored) and `CY_ARMED` (gate on, current limit honoured). Its transitions are:
- *fire*: from any state to BLANK.
- *skip*: from any state to IDLE, with the skip pulse.
- *unblank*: BLANK to ARMED.
- *duty stop*, *current stop* and *protect stop*: any on-state to IDLE.

Top module: `cs_switch_ctrl`

## Requirements
- R1: On a clock edge that samples `cyc_start` high, the gate is driven high from that edge if `fb_en` is high and all protections are clear. Otherwise the gate stays low for the whole period.
- R2: Changes of `fb_en` after the sampling edge have no effect on the gate for the rest of that period.
- R3: A gate pulse never lasts more than MAX_ON = floor(PERIOD_TICKS*DUTY_PCT/100) ticks, and with no other stop it lasts exactly MAX_ON ticks.
- R4: `ilim_trip` high during on-tick c, with c > BLANK_TICKS, ends the pulse after exactly c ticks.
- R5: `ilim_trip` during on-ticks 1..BLANK_TICKS is ignored. If it is held high from turn-on, the pulse lasts BLANK_TICKS+1 ticks.
- R6: `bp_below_lo` forces undervoltage lockout. Lockout is left only on an edge with `bp_above_hi` high and `bp_below_lo` low. Reset enters lockout.
- R7: `ov_trip` latches a shutdown that only `bp_below_rst` clears. If both are high on the same edge, the latch ends up clear.
- R8: `ot_set` enters thermal shutdown and only `ot_clr` leaves it. If both are high on the same edge, shutdown wins.
- R9: A protection flag seen during on-tick j ends a running pulse after j+1 ticks.
- R10: `skip_pulse` is high for exactly the one tick after a sampling edge that did not turn the switch on. It is never high together with `gate`.
- R11: During and right after reset, `gate` and `skip_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast timing clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cyc_start | input | 1 | one-tick pulse marking the start of a switching period |
| fb_en | input | 1 | feedback decision: high requests conduction |
| ilim_trip | input | 1 | switch current above limit |
| bp_below_lo | input | 1 | supply below the undervoltage trip level |
| bp_above_hi | input | 1 | supply at or above the restart level |
| ov_trip | input | 1 | supply overvoltage with excess shunt current |
| bp_below_rst | input | 1 | supply below the latch reset level |
| ot_set | input | 1 | die temperature above the shutdown threshold |
| ot_clr | input | 1 | die temperature below the restart threshold |
| gate | output | 1 | switch drive |
| skip_pulse | output | 1 | one-tick pulse for each skipped period |

## Verification
The bench builds the block with PERIOD_TICKS=20, DUTY_PCT=60 and BLANK_TICKS=3, which gives a 12-tick on-time limit inside a 20-tick period. These small values let the random current-limit instant sweep every on-tick: inside the blanking window, exactly at its edge, in the armed region and past the duty limit. Hundreds of periods stay cheap to run. A protection flag dropped into a chosen on-tick lands in every one of those regions as well.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

    typedef enum logic [1:0] {
        CY_IDLE  = 2'd0,
        CY_BLANK = 2'd1,
        CY_ARMED = 2'd2
    } cy_state_t;

    typedef enum logic {
        UV_LOCK = 1'b0,
        UV_RUN  = 1'b1
    } uv_state_t;

    typedef enum logic {
        OV_CLEAR   = 1'b0,
        OV_TRIPPED = 1'b1
    } ov_state_t;

    typedef enum logic {
        OT_COOL = 1'b0,
        OT_HOT  = 1'b1
    } ot_state_t;

endpackage

// File: rtl/cs_prot_gate.sv
`timescale 1ns/1ps
module cs_prot_gate
    import cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bp_below_lo,
    input  logic bp_above_hi,
    input  logic ov_trip,
    input  logic bp_below_rst,
    input  logic ot_set,
    input  logic ot_clr,
    output logic allow
);

    uv_state_t uv_q, uv_d;
    ov_state_t ov_q, ov_d;
    ot_state_t ot_q, ot_d;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_q <= UV_LOCK;
            ov_q <= OV_CLEAR;
            ot_q <= OT_COOL;
        end else begin
            uv_q <= uv_d;
            ov_q <= ov_d;
            ot_q <= ot_d;
        end
    end

    // undervoltage hysteresis: brown-out / recharged
    always_comb begin
        uv_d = uv_q;
        unique case (uv_q)
            UV_RUN:  if (bp_below_lo) uv_d = UV_LOCK;
            UV_LOCK: if (bp_above_hi && !bp_below_lo) uv_d = UV_RUN;
            default: uv_d = UV_LOCK;
        endcase
    end

    // overvoltage latch: trip / discharge reset (reset wins)
    always_comb begin
        ov_d = ov_q;
        unique case (ov_q)
            OV_CLEAR:   if (ov_trip && !bp_below_rst) ov_d = OV_TRIPPED;
            OV_TRIPPED: if (bp_below_rst) ov_d = OV_CLEAR;
            default:    ov_d = OV_CLEAR;
        endcase
    end

    // thermal shutdown: overheat / cooled (overheat wins)
    always_comb begin
        ot_d = ot_q;
        unique case (ot_q)
            OT_COOL: if (ot_set) ot_d = OT_HOT;
            OT_HOT:  if (ot_clr && !ot_set) ot_d = OT_COOL;
            default: ot_d = OT_HOT;
        endcase
    end

    // output decode
    always_comb begin
        allow = (uv_q == UV_RUN) && (ov_q == OV_CLEAR) && (ot_q == OT_COOL);
    end

    AST_UV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_q == UV_LOCK && !bp_above_hi) |=> (uv_q == UV_LOCK)); // R6
    AST_UV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bp_below_lo |=> !allow); // R6
    AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q == OV_TRIPPED && !bp_below_rst) |=> (ov_q == OV_TRIPPED)); // R7
    AST_OV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_trip && !bp_below_rst) |=> !allow); // R7
    AST_OT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ot_set |=> !allow); // R8
    AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_q == OT_HOT && !ot_clr) |=> (ot_q == OT_HOT)); // R8

endmodule

// File: rtl/cs_ontime_ctr.sv
`timescale 1ns/1ps
module cs_ontime_ctr #(
    parameter int CNT_W        = 6,
    parameter int BLANK_TICKS  = 11,
    parameter int MAX_ON_TICKS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    output logic [CNT_W-1:0] on_cnt,
    output logic             at_blank_end,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK_TICKS);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_ON_TICKS);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // counts the on-tick now in progress, starting at one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ONE_C;
        end else if (run && cnt_q != MAX_C) begin
            cnt_q <= cnt_q + ONE_C;
        end
    end

    always_comb begin
        on_cnt       = cnt_q;
        at_blank_end = (cnt_q == BLANK_C);
        at_max       = (cnt_q == MAX_C);
    end

    AST_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (on_cnt == ONE_C)); // R3
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && at_max) |=> at_max); // R3

endmodule

// File: rtl/cs_cycle_fsm.sv
`timescale 1ns/1ps
module cs_cycle_fsm
    import cs_pkg::*;
#(
    parameter int CNT_W        = 6,
    parameter int BLANK_TICKS  = 11,
    parameter int MAX_ON_TICKS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             fb_en,
    input  logic             ilim_trip,
    input  logic             allow,
    input  logic [CNT_W-1:0] on_cnt,
    input  logic             at_blank_end,
    input  logic             at_max,
    output logic             gate,
    output logic             skip_pulse
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ON_TICKS);

    cy_state_t state_q, state_d;
    logic      skip_q, skip_d;
    logic      fire;

    always_comb begin
        fire = cyc_start && fb_en && allow;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CY_IDLE;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            skip_q  <= skip_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        skip_d  = 1'b0;
        if (cyc_start) begin
            state_d = fire ? CY_BLANK : CY_IDLE;   // fire / skip
            skip_d  = !fire;
        end else begin
            unique case (state_q)
                CY_IDLE: state_d = CY_IDLE;
                CY_BLANK: begin
                    if (!allow)            state_d = CY_IDLE;   // protect stop
                    else if (at_max)       state_d = CY_IDLE;   // duty stop
                    else if (at_blank_end) state_d = CY_ARMED;  // unblank
                end
                CY_ARMED: begin
                    if (!allow || ilim_trip || at_max) state_d = CY_IDLE;
                end
                default: state_d = CY_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        gate       = (state_q == CY_BLANK) || (state_q == CY_ARMED);
        skip_pulse = skip_q;
    end

    AST_START_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(cyc_start) && $past(fb_en) && $past(allow))); // R1
    AST_MAX_ON: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (on_cnt <= MAX_C)); // R3
    AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CY_ARMED && ilim_trip && !cyc_start) |=> !gate); // R4
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CY_BLANK && allow && !at_max && !cyc_start) |=> gate); // R5
    AST_SKIP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        skip_pulse |-> !gate); // R10

endmodule

// File: rtl/cs_switch_ctrl.sv
`timescale 1ns/1ps
module cs_switch_ctrl #(
    parameter int PERIOD_TICKS = 50,
    parameter int DUTY_PCT     = 63,
    parameter int BLANK_TICKS  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic fb_en,
    input  logic ilim_trip,
    input  logic bp_below_lo,
    input  logic bp_above_hi,
    input  logic ov_trip,
    input  logic bp_below_rst,
    input  logic ot_set,
    input  logic ot_clr,
    output logic gate,
    output logic skip_pulse
);

    localparam int MAX_ON_TICKS = (PERIOD_TICKS * DUTY_PCT) / 100;
    localparam int CNT_W        = $clog2(MAX_ON_TICKS + 1);

    logic             allow;
    logic [CNT_W-1:0] on_cnt;
    logic             at_blank_end;
    logic             at_max;
    logic             gate_i;

    cs_prot_gate u_prot (
        .clk          (clk),
        .rst_n        (rst_n),
        .bp_below_lo  (bp_below_lo),
        .bp_above_hi  (bp_above_hi),
        .ov_trip      (ov_trip),
        .bp_below_rst (bp_below_rst),
        .ot_set       (ot_set),
        .ot_clr       (ot_clr),
        .allow        (allow)
    );

    cs_ontime_ctr #(
        .CNT_W        (CNT_W),
        .BLANK_TICKS  (BLANK_TICKS),
        .MAX_ON_TICKS (MAX_ON_TICKS)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (cyc_start),
        .run          (gate_i),
        .on_cnt       (on_cnt),
        .at_blank_end (at_blank_end),
        .at_max       (at_max)
    );

    cs_cycle_fsm #(
        .CNT_W        (CNT_W),
        .BLANK_TICKS  (BLANK_TICKS),
        .MAX_ON_TICKS (MAX_ON_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .fb_en        (fb_en),
        .ilim_trip    (ilim_trip),
        .allow        (allow),
        .on_cnt       (on_cnt),
        .at_blank_end (at_blank_end),
        .at_max       (at_max),
        .gate         (gate_i),
        .skip_pulse   (skip_pulse)
    );

    always_comb begin
        gate = gate_i;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!gate && !skip_pulse)); // R11

endmodule

// File: tb/cs_switch_ctrl_tb.sv
`timescale 1ns/1ps
module cs_switch_ctrl_tb;

    localparam int P = 20;
    localparam int D = 60;
    localparam int B = 3;
    localparam int M = (P * D) / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, fb_en = 1'b0, ilim_trip = 1'b0;
    logic bp_below_lo = 1'b0, bp_above_hi = 1'b0, ov_trip = 1'b0;
    logic bp_below_rst = 1'b0, ot_set = 1'b0, ot_clr = 1'b0;
    logic gate, skip_pulse;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  m_uv_run = 1'b0, m_ov = 1'b0, m_ot = 1'b0;

    cs_switch_ctrl #(.PERIOD_TICKS(P), .DUTY_PCT(D), .BLANK_TICKS(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fb_en(fb_en),
        .ilim_trip(ilim_trip), .bp_below_lo(bp_below_lo), .bp_above_hi(bp_above_hi),
        .ov_trip(ov_trip), .bp_below_rst(bp_below_rst), .ot_set(ot_set),
        .ot_clr(ot_clr), .gate(gate), .skip_pulse(skip_pulse)
    );

    always #10 clk = ~clk;

    function automatic bit model_ok();
        return m_uv_run && !m_ov && !m_ot;
    endfunction

    // pulse length from R1, R3, R4, R5
    function automatic int exp_len(bit fb, bit ok, int t_ilim);
        int l;
        if (!fb || !ok) return 0;
        if (t_ilim == 0) return M;
        l = (t_ilim <= B) ? B + 1 : t_ilim;
        return (l < M) ? l : M;
    endfunction

    task automatic check_int(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_prot(bit lo, bit hi, bit ov, bit rs, bit st, bit cl);
        @(negedge clk);
        bp_below_lo = lo; bp_above_hi = hi; ov_trip = ov;
        bp_below_rst = rs; ot_set = st; ot_clr = cl;
        if (lo) m_uv_run = 1'b0; else if (hi) m_uv_run = 1'b1;       // R6
        if (rs) m_ov = 1'b0; else if (ov) m_ov = 1'b1;               // R7
        if (st) m_ot = 1'b1; else if (cl) m_ot = 1'b0;               // R8
        @(negedge clk);
        bp_below_lo = 0; bp_above_hi = 0; ov_trip = 0;
        bp_below_rst = 0; ot_set = 0; ot_clr = 0;
        @(negedge clk);
    endtask

    task automatic run_cycle(string req, bit fb, int t_ilim, bit toggle, int prot_tick);
        int  len = 0;
        int  skips = 0;
        bit  contig = 1'b1;
        bit  skip_first = 1'b0;
        int  base, exp;
        base = exp_len(fb, model_ok(), t_ilim);
        exp  = (prot_tick > 0 && base > prot_tick) ? prot_tick + 1 : base;   // R9
        @(negedge clk);
        cyc_start = 1'b1; fb_en = fb; ilim_trip = 1'b0;
        for (int j = 1; j <= P; j++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            if (gate) begin
                len++;
                if (len != j) contig = 1'b0;
            end
            if (skip_pulse) begin
                skips++;
                if (j == 1) skip_first = 1'b1;
                if (gate) contig = 1'b0;
            end
            ilim_trip = (t_ilim != 0 && j >= t_ilim);
            if (toggle) fb_en = 1'($urandom % 2);
            bp_below_lo = (prot_tick == j);
        end
        ilim_trip = 1'b0; bp_below_lo = 1'b0;
        if (prot_tick > 0) m_uv_run = 1'b0;
        check_int(req, "on-ticks", contig ? len : -1, exp);
        check_int(req, "skip-ticks(R10)", skips, (exp == 0) ? 1 : 0);
        if (exp == 0) check_int(req, "skip-in-first-tick(R10)", int'(skip_first), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        check_int("R11", "gate in reset", int'(gate), 0);
        check_int("R11", "skip in reset", int'(skip_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R11", "gate after reset", int'(gate), 0);
        check_int("R11", "skip after reset", int'(skip_pulse), 0);

        run_cycle("R6", 1, 0, 0, 0);          // lockout from reset
        apply_prot(0, 1, 0, 0, 0, 0);         // recharged
        run_cycle("R3", 1, 0, 0, 0);
        run_cycle("R1", 0, 0, 0, 0);
        run_cycle("R2", 1, 0, 1, 0);
        run_cycle("R2", 0, 0, 1, 0);
        run_cycle("R5", 1, 1, 0, 0);
        run_cycle("R5", 1, B, 0, 0);
        run_cycle("R4", 1, B + 1, 0, 0);
        run_cycle("R4", 1, B + 3, 0, 0);
        run_cycle("R3", 1, M, 0, 0);
        run_cycle("R3", 1, M + 1, 0, 0);

        apply_prot(0, 0, 1, 0, 0, 0);         // R7 trip
        run_cycle("R7", 1, 0, 0, 0);
        apply_prot(0, 1, 0, 0, 0, 0);
        run_cycle("R7", 1, 0, 0, 0);
        apply_prot(0, 0, 0, 1, 0, 0);
        run_cycle("R7", 1, 0, 0, 0);
        apply_prot(0, 0, 1, 1, 0, 0);         // both: stays clear
        run_cycle("R7", 1, 0, 0, 0);

        apply_prot(0, 0, 0, 0, 1, 0);         // R8 overheat
        run_cycle("R8", 1, 0, 0, 0);
        apply_prot(0, 0, 0, 0, 0, 1);
        run_cycle("R8", 1, 0, 0, 0);
        apply_prot(0, 0, 0, 0, 1, 1);         // both: hot
        run_cycle("R8", 1, 0, 0, 0);
        apply_prot(0, 0, 0, 0, 0, 1);

        apply_prot(1, 0, 0, 0, 0, 0);         // R6 brown-out
        run_cycle("R6", 1, 0, 0, 0);
        apply_prot(1, 1, 0, 0, 0, 0);
        run_cycle("R6", 1, 0, 0, 0);
        apply_prot(0, 1, 0, 0, 0, 0);
        run_cycle("R6", 1, 0, 0, 0);

        run_cycle("R9", 1, 0, 0, 4);
        run_cycle("R9", 1, 0, 0, 1);
        apply_prot(0, 1, 0, 0, 0, 0);

        for (int n = 0; n < 250; n++) begin
            int t, pt;
            bit fb;
            if ($urandom % 6 == 0)
                apply_prot($urandom % 4 == 0, $urandom % 4 == 0, $urandom % 4 == 0,
                           $urandom % 4 == 0, $urandom % 4 == 0, $urandom % 4 == 0);
            if (!model_ok() && ($urandom % 2 == 0))
                apply_prot(0, 1, 0, 1, 0, 1);
            fb = ($urandom % 4) != 0;
            t  = int'($urandom % (M + 3));
            pt = ($urandom % 10 == 0) ? int'(1 + $urandom % M) : 0;
            run_cycle(pt > 0 ? "R9" : (t > B ? "R4" : "R1"), fb, t, 1, pt);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule